// File: doc/BRIEF.md
# Slow Three-Wire Sensor Frame Reader

This block is the host end of a very slow three-wire serial link to a hardware-monitor device. The link has an active-low select, a clock driven by the host and a single data line driven by the device. When a read is requested, the block lowers select and waits a long settling interval. It then clocks in one 32-bit frame, with equal low and high clock phases, and checks the leading marker byte. It presents the fan speed field and the temperature field, together with a completion pulse and a marker error flag.

The device is slow to read, and one transaction returns both readings. The block therefore enforces a minimum spacing between real bus transactions. A request that arrives inside that hold-off window completes at once and leaves the last stored readings on the outputs. The settling time, the clock phase length and the hold-off window are all parameters counted in system clock cycles. Scaling the raw fields into engineering units is left to the consumer.

Top module: `sensor_frame_reader`

## Requirements
- R1: After reset, `link_cs_n` is 1, `link_sck` is 0, and `busy`, `done`, `marker_err`, `fan` and `temp` are all 0.
- R2: Whenever `link_cs_n` is high, `link_sck` is low. A bus transaction begins only in the cycle after `req` is sampled high while the block is idle.
- R3: The first rising edge of `link_sck` comes exactly SETUP_CYC + PHASE_CYC cycles after `link_cs_n` falls.
- R4: Every clock high phase lasts PHASE_CYC cycles, and every low phase between two rising edges also lasts PHASE_CYC cycles. A transaction has exactly 32 rising edges. `link_sdi` is captured at each rising edge, and the first bit captured is frame bit 31.
- R5: Frame bits 31:24 carry the marker, bits 23:16 the fan field and bits 15:0 the temperature field. When the marker equals 0x55, `fan` and `temp` take the received fields and `marker_err` reads 0.
- R6: `link_cs_n` rises and `link_sck` falls on the same edge that ends the 32nd high phase. `done` pulses for one cycle in the next cycle, with `busy` low in that cycle.
- R7: If `req` arrives fewer than HOLDOFF_CYC cycles after the previous transaction began, `done` is raised in the next cycle and there is no bus activity. `fan`, `temp` and `marker_err` keep their values.
- R8: If the marker is not 0x55, `marker_err` reads 1 when `done` is raised, and `fan` and `temp` keep their previous values.
- R9: `fan` and `temp` change only in a cycle where `done` is high. A good frame updates both of them in the same cycle.
- R10: While `req` is held high, successive bus transactions begin exactly HOLDOFF_CYC cycles apart.
- R11: A `req` that arrives while `busy` is high is ignored. It produces no extra transaction and no extra `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Read request, sampled while idle |
| link_cs_n | output | 1 | Active-low select to the device |
| link_sck | output | 1 | Serial clock to the device, idles low |
| link_sdi | input | 1 | Serial data from the device |
| busy | output | 1 | High while a bus transaction is in progress |
| done | output | 1 | One-cycle completion pulse (bus or cached) |
| marker_err | output | 1 | Last bus frame had a bad marker |
| fan | output | 8 | Last good fan field (units of 100 RPM) |
| temp | output | 16 | Last good temperature field (units of 0.1 degree) |

## Verification
The bench builds the block with SETUP_CYC = 20, PHASE_CYC = 3 and HOLDOFF_CYC = 400. With these values a whole transaction takes about 215 cycles. That leaves room, inside one hold-off window, for a cached request placed right after a bus read, and it lets the exact start-to-start spacing be measured with `req` held high. The short phase length also makes the exact-cycle checks on select setup, phase widths and the select-release-to-done ordering quick to run. A device model in the bench shifts out chosen frames, including a bad marker and all-ones and all-zero fields.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_LOW,
      ST_HIGH,
      ST_FINISH
   } rd_state_t;

   localparam int FRAME_W  = 32;
   localparam int MARK_MSB = 31;
   localparam int MARK_LSB = 24;
   localparam int FAN_MSB  = 23;
   localparam int FAN_LSB  = 16;
   localparam int TEMP_MSB = 15;
   localparam int TEMP_LSB = 0;

endpackage

// File: rtl/sfr_countdown.sv
module sfr_countdown #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sfr_shift_in.sv
module sfr_shift_in #(
   parameter int W         = 32,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] word
);
   logic [W-1:0] sr_q;
   logic [W-1:0] sr_next;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sr_next = {sr_q[W-2:0], din};
      end else begin : g_lsb
         assign sr_next = {din, sr_q[W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sr_q <= '0;
      else if (clear)
         sr_q <= '0;
      else if (shift_en)
         sr_q <= sr_next;
   end

   assign word = sr_q;
endmodule

// File: rtl/sensor_frame_reader.sv
module sensor_frame_reader
   import sfr_pkg::*;
#(
   parameter int          SETUP_CYC   = 5_000_000,
   parameter int          PHASE_CYC   = 5_000,
   parameter int          HOLDOFF_CYC = 50_000_000,
   parameter logic [7:0]  MARKER_VAL  = 8'h55
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   output logic        link_cs_n,
   output logic        link_sck,
   input  logic        link_sdi,
   output logic        busy,
   output logic        done,
   output logic        marker_err,
   output logic [7:0]  fan,
   output logic [15:0] temp
);
   localparam int SETUP_W = $clog2(SETUP_CYC + 1);
   localparam int PHASE_W = $clog2(PHASE_CYC + 1);
   localparam int PH_W    = (SETUP_W > PHASE_W) ? SETUP_W : PHASE_W;
   localparam int HOLD_W  = $clog2(HOLDOFF_CYC + 1);
   localparam int BIT_W   = $clog2(FRAME_W);
   localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_W - 1);
   localparam logic [PH_W-1:0]  SETUP_LD  = PH_W'(SETUP_CYC - 1);
   localparam logic [PH_W-1:0]  PHASE_LD  = PH_W'(PHASE_CYC - 1);
   localparam logic [HOLD_W-1:0] HOLD_LD  = HOLD_W'(HOLDOFF_CYC - 1);

   generate
      if (SETUP_CYC < 1) begin : g_bad_setup
         $error("SETUP_CYC must be at least 1");
      end
      if (PHASE_CYC < 1) begin : g_bad_phase
         $error("PHASE_CYC must be at least 1");
      end
      if (HOLDOFF_CYC < 1) begin : g_bad_hold
         $error("HOLDOFF_CYC must be at least 1");
      end
      if (FAN_MSB - FAN_LSB != 7 || TEMP_MSB - TEMP_LSB != 15 || MARK_MSB - MARK_LSB != 7) begin : g_bad_layout
         $error("frame field layout does not match port widths");
      end
   endgenerate

   rd_state_t         state_q;
   logic [BIT_W-1:0]  bit_q;
   logic              cs_n_q, sck_q, busy_q, done_q, err_q;
   logic [7:0]        fan_q;
   logic [15:0]       temp_q;

   logic              ph_load, ph_zero, hold_load, hold_zero;
   logic [PH_W-1:0]   ph_val;
   logic              sh_clear, sh_en;
   logic [FRAME_W-1:0] frame_w;
   logic              start, last_bit;

   assign start    = (state_q == ST_IDLE) && req && hold_zero;
   assign last_bit = (bit_q == LAST_BIT);

   always_comb begin
      ph_load   = 1'b0;
      ph_val    = PHASE_LD;
      hold_load = 1'b0;
      sh_clear  = 1'b0;
      sh_en     = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start) begin
            ph_load   = 1'b1;
            ph_val    = SETUP_LD;
            hold_load = 1'b1;
            sh_clear  = 1'b1;
         end
         ST_SETUP: ph_load = ph_zero;
         ST_LOW: begin
            ph_load = ph_zero;
            sh_en   = ph_zero;
         end
         ST_HIGH: ph_load = ph_zero && !last_bit;
         default: ;
      endcase
   end

   sfr_countdown #(.W(PH_W)) phase_tmr_i (
      .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
   );

   sfr_countdown #(.W(HOLD_W)) hold_tmr_i (
      .clk(clk), .rst_n(rst_n), .load(hold_load), .load_val(HOLD_LD), .zero(hold_zero)
   );

   sfr_shift_in #(.W(FRAME_W), .MSB_FIRST(1'b1)) shift_i (
      .clk(clk), .rst_n(rst_n), .clear(sh_clear), .shift_en(sh_en),
      .din(link_sdi), .word(frame_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         cs_n_q  <= 1'b1;
         sck_q   <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         fan_q   <= '0;
         temp_q  <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_SETUP;
                  cs_n_q  <= 1'b0;
                  busy_q  <= 1'b1;
                  bit_q   <= '0;
               end else if (req) begin
                  done_q <= 1'b1;
               end
            end
            ST_SETUP: if (ph_zero) state_q <= ST_LOW;
            ST_LOW: if (ph_zero) begin
               state_q <= ST_HIGH;
               sck_q   <= 1'b1;
            end
            ST_HIGH: if (ph_zero) begin
               sck_q <= 1'b0;
               if (last_bit) begin
                  state_q <= ST_FINISH;
                  cs_n_q  <= 1'b1;
               end else begin
                  state_q <= ST_LOW;
                  bit_q   <= bit_q + 1'b1;
               end
            end
            ST_FINISH: begin
               state_q <= ST_IDLE;
               busy_q  <= 1'b0;
               done_q  <= 1'b1;
               if (frame_w[MARK_MSB:MARK_LSB] == MARKER_VAL) begin
                  err_q  <= 1'b0;
                  fan_q  <= frame_w[FAN_MSB:FAN_LSB];
                  temp_q <= frame_w[TEMP_MSB:TEMP_LSB];
               end else begin
                  err_q  <= 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign link_cs_n  = cs_n_q;
   assign link_sck   = sck_q;
   assign busy       = busy_q;
   assign done       = done_q;
   assign marker_err = err_q;
   assign fan        = fan_q;
   assign temp       = temp_q;
endmodule

// File: rtl/sfr_checker.sv
module sfr_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        req,
   input logic        link_cs_n,
   input logic        link_sck,
   input logic        busy,
   input logic        done,
   input logic        marker_err,
   input logic [7:0]  fan,
   input logic [15:0] temp
);
   a_r2_sck_idle_outside_select: assert property (@(posedge clk) disable iff (!rst_n)
      link_cs_n |-> !link_sck);

   a_r2_select_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(link_cs_n) |-> $past(req) && !$past(busy));

   a_r6_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> link_cs_n && !link_sck && !busy);

   a_r6_done_single_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r9_fields_move_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      !($stable(fan) && $stable(temp)) |-> done);

   a_r8_err_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(marker_err) |-> done);

   a_r11_select_low_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !link_cs_n |-> busy);
endmodule

bind sensor_frame_reader sfr_checker chk_i (
   .clk(clk), .rst_n(rst_n), .req(req), .link_cs_n(link_cs_n), .link_sck(link_sck),
   .busy(busy), .done(done), .marker_err(marker_err), .fan(fan), .temp(temp)
);

// File: tb/sensor_frame_reader_tb_top.sv
module sensor_frame_reader_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SETUP = 20;
   localparam int PHASE = 3;
   localparam int HOLD  = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic link_sdi = 1'b0;
   logic link_cs_n, link_sck, busy, done, marker_err;
   logic [7:0]  fan;
   logic [15:0] temp;

   int checks = 0;
   int errors = 0;
   logic [31:0] dev_frame = 32'h0;
   int dev_idx = 0;

   int cyc = 0;
   int cs_falls = 0, done_cnt = 0, rises = 0, phase_bad = 0;
   int last_fall_cyc = 0, prev_fall_cyc = 0, first_rise_cyc = -1;
   int last_rise_cyc = 0, last_sckfall_cyc = 0, cs_rise_cyc = 0;
   logic prev_cs = 1'b1, prev_sck = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sensor_frame_reader #(
      .SETUP_CYC(SETUP), .PHASE_CYC(PHASE), .HOLDOFF_CYC(HOLD), .MARKER_VAL(8'h55)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .link_cs_n(link_cs_n), .link_sck(link_sck),
      .link_sdi(link_sdi), .busy(busy), .done(done), .marker_err(marker_err),
      .fan(fan), .temp(temp)
   );

   // device model: bit 31 first, next bit after each falling clock edge
   always @(negedge link_cs_n) begin
      dev_idx  = 31;
      link_sdi = dev_frame[31];
   end
   always @(negedge link_sck) begin
      if (!link_cs_n && dev_idx > 0) begin
         dev_idx  = dev_idx - 1;
         link_sdi = dev_frame[dev_idx];
      end
   end

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_cs && !link_cs_n) begin
            cs_falls++;
            prev_fall_cyc  = last_fall_cyc;
            last_fall_cyc  = cyc;
            rises          = 0;
            first_rise_cyc = -1;
            phase_bad      = 0;
         end
         if (!prev_cs && link_cs_n) cs_rise_cyc = cyc;
         if (!prev_sck && link_sck) begin
            rises++;
            if (first_rise_cyc < 0) first_rise_cyc = cyc;
            else if (cyc - last_sckfall_cyc != PHASE) phase_bad++;
            last_rise_cyc = cyc;
         end
         if (prev_sck && !link_sck) begin
            if (cyc - last_rise_cyc != PHASE) phase_bad++;
            last_sckfall_cyc = cyc;
         end
         if (done) done_cnt++;
         prev_cs  = link_cs_n;
         prev_sck = link_sck;
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   task automatic pulse_req();
      @(negedge clk) req = 1'b1;
      @(negedge clk) req = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      int n = 0;
      seen = done;
      while (!seen && n < 3000) begin
         @(negedge clk);
         n++;
         seen = done;
      end
   endtask

   task automatic idle_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(link_cs_n === 1'b1, "R1", "cs_n after reset", 32'(link_cs_n), 1);
      chk(link_sck === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "sck/busy/done after reset",
          {29'd0, link_sck, busy, done}, 0);
      chk(marker_err === 1'b0 && fan === 8'h0 && temp === 16'h0, "R1", "outputs after reset",
          {7'd0, marker_err, fan, temp}, 0);
   endtask

   task automatic bus_read(input logic [31:0] frame, input string tag, output bit seen);
      int f0;
      dev_frame = frame;
      f0 = cs_falls;
      pulse_req();
      wait_done(seen);
      chk(seen, tag, "done seen", 32'(seen), 1);
      chk(cs_falls == f0 + 1, "R2", "one select pulse", 32'(cs_falls - f0), 1);
      chk(first_rise_cyc - last_fall_cyc == SETUP + PHASE, "R3", "select to first clock rise",
          32'(first_rise_cyc - last_fall_cyc), SETUP + PHASE);
      chk(rises == 32, "R4", "rising edges per frame", 32'(rises), 32);
      chk(phase_bad == 0, "R4", "phases of wrong width", 32'(phase_bad), 0);
      chk(cyc - cs_rise_cyc == 1 && link_cs_n && !link_sck && !busy, "R6",
          "select release one cycle before done", 32'(cyc - cs_rise_cyc), 1);
      @(negedge clk);
      chk(!done, "R6", "done lasts one cycle", 32'(done), 0);
   endtask

   task automatic t_good_frame();
      bit seen;
      bus_read(32'h552A_0123, "R5", seen);
      chk(fan == 8'h2A && temp == 16'h0123 && !marker_err, "R5", "good frame fields",
          {7'd0, marker_err, fan, temp}, {8'h0, 8'h2A, 16'h0123});
   endtask

   task automatic t_cached();
      int f0 = cs_falls;
      dev_frame = 32'h5511_2222;
      @(negedge clk) req = 1'b1;
      @(negedge clk) req = 1'b0;
      chk(done === 1'b1 && busy === 1'b0, "R7", "cached request completes next cycle",
          {30'd0, done, busy}, 2);
      idle_wait(30);
      chk(cs_falls == f0, "R7", "no bus activity for cached request", 32'(cs_falls - f0), 0);
      chk(fan == 8'h2A && temp == 16'h0123, "R7", "cached values kept", {8'h0, fan, temp},
          {8'h0, 8'h2A, 16'h0123});
   endtask

   task automatic t_bad_marker();
      bit seen;
      idle_wait(HOLD);
      bus_read(32'h54FF_FFFF, "R8", seen);
      chk(marker_err === 1'b1, "R8", "marker error flagged", 32'(marker_err), 1);
      chk(fan == 8'h2A && temp == 16'h0123, "R8", "fields kept after bad marker",
          {8'h0, fan, temp}, {8'h0, 8'h2A, 16'h0123});
   endtask

   task automatic t_boundary_and_busy();
      int d0, f0;
      bit seen;
      idle_wait(HOLD);
      dev_frame = 32'h5500_FFFF;
      f0 = cs_falls;
      pulse_req();
      idle_wait(60);
      d0 = done_cnt;
      pulse_req();  // lands while busy
      wait_done(seen);
      idle_wait(10);
      chk(done_cnt - d0 == 1, "R11", "request during busy gives no extra done",
          32'(done_cnt - d0), 1);
      chk(cs_falls - f0 == 1, "R11", "request during busy gives no extra transaction",
          32'(cs_falls - f0), 1);
      chk(fan == 8'h00 && temp == 16'hFFFF && !marker_err, "R9", "both fields updated together",
          {7'd0, marker_err, fan, temp}, {8'h0, 8'h00, 16'hFFFF});
   endtask

   task automatic t_spacing();
      int f0, n;
      idle_wait(HOLD);
      dev_frame = 32'h5503_0040;
      f0 = cs_falls;
      n  = 0;
      @(negedge clk) req = 1'b1;
      while (cs_falls < f0 + 2 && n < 2000) begin
         @(negedge clk);
         n++;
      end
      req = 1'b0;
      chk(cs_falls == f0 + 2, "R10", "two transactions under held request", 32'(cs_falls - f0), 2);
      chk(last_fall_cyc - prev_fall_cyc == HOLD, "R10", "start-to-start spacing",
          32'(last_fall_cyc - prev_fall_cyc), HOLD);
      n = 0;
      while ((busy || !link_cs_n) && n < 1000) begin
         @(negedge clk);
         n++;
      end
      idle_wait(3);
      chk(fan == 8'h03 && temp == 16'h0040, "R5", "held-request frame fields", {8'h0, fan, temp},
          {8'h0, 8'h03, 16'h0040});
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_good_frame();
      t_cached();
      t_bad_marker();
      t_boundary_and_busy();
      t_spacing();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule